// File: doc/BRIEF.md
# Panel Reset and Window Sequencer

This block drives a small display panel through a byte-wide command link that sits below it. Each byte goes out with a flag that marks it as a command (flag low) or as a parameter or data byte (flag high). The link itself turns these bytes into serial frames. On an init request the block brings the panel out of reset. In the conditional form it first reads the panel's power-mode register, and it leaves the panel alone when that value shows the display already running. Otherwise it pulses the panel reset line, sends a soft-reset command and holds off for a settle time. That time is long when no hardware reset line is fitted and short when the pulse was actually given.

A flush request takes a rectangle with inclusive start corners and exclusive end bounds. The block programs the column range and the row range, then sends the memory-write command. After that it streams the 16-bit pixels from a valid/ready source, upper byte first. A blank request does the same over the whole panel from the origin and sends zero pixels without touching the source. All delays are parameters in microseconds and are turned into clock cycles from the clock frequency parameter.

Top module: `panel_seq`

## Requirements
- R1: After reset, busy, link valid, read request and pixel ready are low, and the panel reset output is high.
- R2: A flush first sends command 0x2A, then four parameter bytes: start column upper byte, start column lower byte, then the upper and lower bytes of (exclusive right bound − 1). It then sends command 0x2B with the four row bytes in the same layout. Commands carry flag 0 and parameters carry flag 1.
- R3: After the window, the block sends command 0x2C and then exactly width × height pixels as width × height × 2 data bytes (flag 1). Each pixel goes upper byte first, in the order the pixel source offered them.
- R4: An unconditional init, with a hardware reset fitted, drives the panel reset output low for at least RST_LOW_US and no longer than 1 ms. No link byte goes out during the pulse. The first byte after release is soft-reset command 0x01.
- R5: After the soft reset that follows a hardware pulse, the block stays busy for at least SETTLE_HW_US worth of cycles and sends nothing before it returns to idle.
- R6: With no hardware reset fitted (HAS_HWRST = 0), the reset output never goes low. Init sends 0x01 and then waits at least SETTLE_SW_US.
- R7: A conditional init sends command 0x0A and raises the read request. If the returned byte, with bits 0, 1 and 7 ignored, equals 0x1C, the block goes idle with no reset pulse and no further bytes.
- R8: If the returned value differs from that pattern in any bit other than 0, 1 and 7, or if no response arrives within RD_TIMEOUT cycles, the full reset path of R4 and R5 follows.
- R9: A blank request programs the window from (0,0) to (PANEL_W−1, PANEL_H−1) and sends PANEL_W × PANEL_H × 2 zero data bytes. It never raises pixel ready.
- R10: Busy rises in the cycle after a request is accepted and falls right after the last byte has been handed to the link. Requests that arrive while busy are dropped, not queued.
- R11: When several requests arrive in the same idle cycle, init wins over blank and blank wins over flush.
- R12: A command byte offered to the link stays valid and unchanged until the link accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Start the power-up sequence |
| init_cond | input | 1 | With init_req: check power mode first |
| flush_req | input | 1 | Start a window update from the pixel source |
| blank_req | input | 1 | Zero the whole panel |
| win_x0 | input | COORD_W | First column of the flush window |
| win_y0 | input | COORD_W | First row of the flush window |
| win_x1 | input | COORD_W | Exclusive right bound |
| win_y1 | input | COORD_W | Exclusive bottom bound |
| pix_valid | input | 1 | Pixel source has a pixel |
| pix_data | input | 16 | RGB565 pixel |
| pix_ready | output | 1 | Pixel taken this cycle |
| lnk_valid | output | 1 | Byte offered to the link |
| lnk_ready | input | 1 | Link takes the byte |
| lnk_dc | output | 1 | 0 command, 1 parameter/data |
| lnk_byte | output | 8 | Byte to the link |
| lnk_rd_req | output | 1 | Waiting for a read response |
| lnk_rd_valid | input | 1 | Read response present |
| lnk_rd_data | input | 8 | Read response byte |
| pnl_rst_n | output | 1 | Panel hardware reset, active low |
| busy | output | 1 | Sequence in progress |

## Verification
Flush windows are tried at the single corner pixels, at the full panel and across the 255/256 column boundary. The boundary case shows whether the upper coordinate byte and the minus-one end are formed correctly. Random small windows under random link stalls and source gaps show whether pixel order and count survive back-pressure. Power-mode responses are tried as the on pattern with the ignored bits set, as the reset default, as a value with one significant extra bit, and as no response at all, which separates masking from a plain compare. Two instances, one with and one without a hardware reset line, show the choice between the two settle lengths.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PM_CMD, ST_PM_RD, ST_HW_LOW, ST_SRST, ST_SETTLE,
    ST_COL_CMD, ST_COL_PAR, ST_ROW_CMD, ST_ROW_PAR, ST_MEMW_CMD,
    ST_PIX_HI, ST_PIX_LO
  } seq_state_e;

  localparam logic [7:0] OP_PM_READ = 8'h0A;
  localparam logic [7:0] OP_SRESET  = 8'h01;
  localparam logic [7:0] OP_COLSET  = 8'h2A;
  localparam logic [7:0] OP_ROWSET  = 8'h2B;
  localparam logic [7:0] OP_MEMWR   = 8'h2C;

  localparam logic [7:0] PM_DONT_CARE = 8'h83;
  localparam logic [7:0] PM_ON_VALUE  = 8'h1C;

  // microseconds to clock cycles, rounded up
  function automatic longint unsigned us_to_cycles(input longint unsigned us,
                                                   input longint unsigned hz);
    return (us * hz + 64'd999_999) / 64'd1_000_000;
  endfunction

  function automatic logic pm_is_on(input logic [7:0] v);
    return (v & ~PM_DONT_CARE) == PM_ON_VALUE;
  endfunction

  // parameter byte idx of a range command: start hi, start lo, end hi, end lo
  function automatic logic [7:0] win_byte(input logic [15:0] first,
                                          input logic [15:0] bound,
                                          input logic [1:0]  idx);
    logic [15:0] last;
    last = bound - 16'd1;
    case (idx)
      2'd0:    return first[15:8];
      2'd1:    return first[7:0];
      2'd2:    return last[15:8];
      default: return last[7:0];
    endcase
  endfunction

  function automatic logic [31:0] win_area(input logic [15:0] x0, input logic [15:0] x1,
                                           input logic [15:0] y0, input logic [15:0] y1);
    logic [31:0] w, h;
    w = 32'(x1 - x0);
    h = 32'(y1 - y0);
    return w * h;
  endfunction

endpackage

// File: rtl/panel_seq_timer.sv
module panel_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // a fresh load of a nonzero value is never reported as expired next cycle
  AST_TMR_LOAD_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    load && (load_val != '0) |=> !expired);  // R5

endmodule

// File: rtl/panel_seq_pixcnt.sv
module panel_seq_pixcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (dec)   cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

  AST_PIX_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> cnt_q != '0);  // R3

endmodule

// File: rtl/panel_seq.sv
module panel_seq
  import panel_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 50_000_000,
  parameter int              PANEL_W      = 240,
  parameter int              PANEL_H      = 320,
  parameter int              COORD_W      = 16,
  parameter bit              HAS_HWRST    = 1'b1,
  parameter longint unsigned RST_LOW_US   = 20,
  parameter longint unsigned SETTLE_HW_US = 5000,
  parameter longint unsigned SETTLE_SW_US = 120000,
  parameter int              RD_TIMEOUT   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_req,
  input  logic               init_cond,
  input  logic               flush_req,
  input  logic               blank_req,
  input  logic [COORD_W-1:0] win_x0,
  input  logic [COORD_W-1:0] win_y0,
  input  logic [COORD_W-1:0] win_x1,
  input  logic [COORD_W-1:0] win_y1,
  input  logic               pix_valid,
  input  logic [15:0]        pix_data,
  output logic               pix_ready,
  output logic               lnk_valid,
  input  logic               lnk_ready,
  output logic               lnk_dc,
  output logic [7:0]         lnk_byte,
  output logic               lnk_rd_req,
  input  logic               lnk_rd_valid,
  input  logic [7:0]         lnk_rd_data,
  output logic               pnl_rst_n,
  output logic               busy
);

  localparam longint unsigned RST_CYC = us_to_cycles(RST_LOW_US, CLK_HZ);
  localparam longint unsigned HW_CYC  = us_to_cycles(SETTLE_HW_US, CLK_HZ);
  localparam longint unsigned SW_CYC  = us_to_cycles(SETTLE_SW_US, CLK_HZ);
  localparam longint unsigned MAX_A   = (HW_CYC > SW_CYC) ? HW_CYC : SW_CYC;
  localparam longint unsigned MAX_B   = (RST_CYC > longint'(RD_TIMEOUT)) ? RST_CYC : longint'(RD_TIMEOUT);
  localparam longint unsigned TMR_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W = $clog2(TMR_MAX + 1) + 1;
  localparam int PIX_W = 2 * COORD_W;
  localparam logic [TMR_W-1:0] RST_V = TMR_W'(RST_CYC);
  localparam logic [TMR_W-1:0] HW_V  = TMR_W'(HW_CYC);
  localparam logic [TMR_W-1:0] SW_V  = TMR_W'(SW_CYC);
  localparam logic [TMR_W-1:0] RD_V  = TMR_W'(RD_TIMEOUT);

  seq_state_e         state_q, state_d;
  logic               blank_q, hw_done_q;
  logic [COORD_W-1:0] x0_q, y0_q, x1_q, y1_q;
  logic [1:0]         pidx_q;
  logic [7:0]         lo_q;

  logic               tmr_load, tmr_exp;
  logic [TMR_W-1:0]   tmr_val;
  logic               pc_load, pc_dec, pc_last;
  logic               hs;

  // named events for the checks
  logic req_accept, pm_on_seen, last_pix_hs;

  assign hs          = lnk_valid && lnk_ready;
  assign req_accept  = (state_q == ST_IDLE) && (init_req || blank_req || flush_req);
  assign pm_on_seen  = (state_q == ST_PM_RD) && lnk_rd_valid && pm_is_on(lnk_rd_data);
  assign last_pix_hs = (state_q == ST_PIX_LO) && hs && pc_last;

  // link byte offered in each state
  always_comb begin
    lnk_valid = 1'b0;
    lnk_dc    = 1'b0;
    lnk_byte  = 8'h00;
    case (state_q)
      ST_PM_CMD:   begin lnk_valid = 1'b1; lnk_byte = OP_PM_READ; end
      ST_SRST:     begin lnk_valid = 1'b1; lnk_byte = OP_SRESET;  end
      ST_COL_CMD:  begin lnk_valid = 1'b1; lnk_byte = OP_COLSET;  end
      ST_ROW_CMD:  begin lnk_valid = 1'b1; lnk_byte = OP_ROWSET;  end
      ST_MEMW_CMD: begin lnk_valid = 1'b1; lnk_byte = OP_MEMWR;   end
      ST_COL_PAR:  begin
        lnk_valid = 1'b1; lnk_dc = 1'b1;
        lnk_byte  = win_byte(16'(x0_q), 16'(x1_q), pidx_q);
      end
      ST_ROW_PAR:  begin
        lnk_valid = 1'b1; lnk_dc = 1'b1;
        lnk_byte  = win_byte(16'(y0_q), 16'(y1_q), pidx_q);
      end
      ST_PIX_HI:   begin
        lnk_valid = blank_q || pix_valid; lnk_dc = 1'b1;
        lnk_byte  = blank_q ? 8'h00 : pix_data[15:8];
      end
      ST_PIX_LO:   begin lnk_valid = 1'b1; lnk_dc = 1'b1; lnk_byte = lo_q; end
      default: ;
    endcase
  end

  assign pix_ready  = (state_q == ST_PIX_HI) && !blank_q && hs;
  assign lnk_rd_req = (state_q == ST_PM_RD);
  assign pnl_rst_n  = (state_q != ST_HW_LOW);
  assign busy       = (state_q != ST_IDLE);

  // next state
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    pc_load  = 1'b0;
    pc_dec   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (init_req) begin
          if (init_cond) state_d = ST_PM_CMD;
          else if (HAS_HWRST) begin state_d = ST_HW_LOW; tmr_load = 1'b1; tmr_val = RST_V; end
          else state_d = ST_SRST;
        end else if (blank_req || flush_req) begin
          state_d = ST_COL_CMD;
        end
      end
      ST_PM_CMD: if (hs) begin state_d = ST_PM_RD; tmr_load = 1'b1; tmr_val = RD_V; end
      ST_PM_RD: begin
        if (pm_on_seen) state_d = ST_IDLE;
        else if (lnk_rd_valid || tmr_exp) begin
          if (HAS_HWRST) begin state_d = ST_HW_LOW; tmr_load = 1'b1; tmr_val = RST_V; end
          else state_d = ST_SRST;
        end
      end
      ST_HW_LOW: if (tmr_exp) state_d = ST_SRST;
      ST_SRST: if (hs) begin
        state_d  = ST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = hw_done_q ? HW_V : SW_V;
      end
      ST_SETTLE:   if (tmr_exp) state_d = ST_IDLE;
      ST_COL_CMD:  if (hs) state_d = ST_COL_PAR;
      ST_COL_PAR:  if (hs && pidx_q == 2'd3) state_d = ST_ROW_CMD;
      ST_ROW_CMD:  if (hs) state_d = ST_ROW_PAR;
      ST_ROW_PAR:  if (hs && pidx_q == 2'd3) state_d = ST_MEMW_CMD;
      ST_MEMW_CMD: if (hs) begin state_d = ST_PIX_HI; pc_load = 1'b1; end
      ST_PIX_HI:   if (hs) state_d = ST_PIX_LO;
      ST_PIX_LO:   if (hs) begin
        pc_dec  = 1'b1;
        state_d = pc_last ? ST_IDLE : ST_PIX_HI;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      blank_q   <= 1'b0;
      hw_done_q <= 1'b0;
      x0_q <= '0; y0_q <= '0; x1_q <= '0; y1_q <= '0;
      pidx_q    <= 2'd0;
      lo_q      <= 8'h00;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) begin
        if (init_req) begin
          hw_done_q <= 1'b0;
        end else if (blank_req) begin
          blank_q <= 1'b1;
          x0_q <= '0; y0_q <= '0;
          x1_q <= COORD_W'(PANEL_W); y1_q <= COORD_W'(PANEL_H);
        end else if (flush_req) begin
          blank_q <= 1'b0;
          x0_q <= win_x0; y0_q <= win_y0; x1_q <= win_x1; y1_q <= win_y1;
        end
      end
      if (state_q == ST_HW_LOW) hw_done_q <= 1'b1;
      if (hs && (state_q == ST_COL_PAR || state_q == ST_ROW_PAR)) pidx_q <= pidx_q + 2'd1;
      if (hs && state_q == ST_PIX_HI) lo_q <= blank_q ? 8'h00 : pix_data[7:0];
    end
  end

  panel_seq_timer #(.CNT_W(TMR_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  panel_seq_pixcnt #(.CNT_W(PIX_W)) pc_i (
    .clk(clk), .rst_n(rst_n), .load(pc_load),
    .load_val(PIX_W'(win_area(16'(x0_q), 16'(x1_q), 16'(y0_q), 16'(y1_q)))),
    .dec(pc_dec), .last(pc_last)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !lnk_valid && !lnk_rd_req && pnl_rst_n);  // R10
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> busy);  // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    last_pix_hs |=> !busy);  // R10
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_valid && !lnk_ready && !lnk_dc |=> lnk_valid && !lnk_dc && $stable(lnk_byte));  // R12
  AST_SRST_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pnl_rst_n) |-> lnk_valid && !lnk_dc && lnk_byte == OP_SRESET);  // R4
  AST_QUIET_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !pnl_rst_n |-> !lnk_valid);  // R4
  AST_SKIP_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    pm_on_seen |=> !busy && pnl_rst_n);  // R7

endmodule

// File: tb/panel_seq_tb_top.sv
module panel_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam longint unsigned HZ = 200_000;
  localparam int PW = 260;
  localparam int PH = 3;
  localparam int RDTO = 16;
  localparam int LOGN = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic init_req = 0, init_cond = 0, flush_req = 0, blank_req = 0, sw_init_req = 0;
  logic [15:0] win_x0 = 0, win_y0 = 0, win_x1 = 1, win_y1 = 1;
  logic pix_valid = 0, lnk_ready = 0, lnk_rd_valid = 0;
  logic [7:0] lnk_rd_data = 0;
  logic pix_ready, lnk_valid, lnk_dc, lnk_rd_req, pnl_rst_n, busy;
  logic [7:0] lnk_byte;
  logic [15:0] pix_data;
  logic sw_pix_ready, sw_valid, sw_dc, sw_rd_req, sw_rst_n, sw_busy;
  logic [7:0] sw_byte;

  panel_seq #(.CLK_HZ(HZ), .PANEL_W(PW), .PANEL_H(PH), .COORD_W(16), .HAS_HWRST(1'b1),
              .RD_TIMEOUT(RDTO)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_cond(init_cond),
    .flush_req(flush_req), .blank_req(blank_req),
    .win_x0(win_x0), .win_y0(win_y0), .win_x1(win_x1), .win_y1(win_y1),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .lnk_valid(lnk_valid), .lnk_ready(lnk_ready), .lnk_dc(lnk_dc), .lnk_byte(lnk_byte),
    .lnk_rd_req(lnk_rd_req), .lnk_rd_valid(lnk_rd_valid), .lnk_rd_data(lnk_rd_data),
    .pnl_rst_n(pnl_rst_n), .busy(busy));

  panel_seq #(.CLK_HZ(HZ), .PANEL_W(PW), .PANEL_H(PH), .COORD_W(16), .HAS_HWRST(1'b0),
              .RD_TIMEOUT(RDTO)) dut_sw_i (
    .clk(clk), .rst_n(rst_n), .init_req(sw_init_req), .init_cond(1'b0),
    .flush_req(1'b0), .blank_req(1'b0),
    .win_x0(16'd0), .win_y0(16'd0), .win_x1(16'd1), .win_y1(16'd1),
    .pix_valid(1'b0), .pix_data(16'h0000), .pix_ready(sw_pix_ready),
    .lnk_valid(sw_valid), .lnk_ready(lnk_ready), .lnk_dc(sw_dc), .lnk_byte(sw_byte),
    .lnk_rd_req(sw_rd_req), .lnk_rd_valid(1'b0), .lnk_rd_data(8'h00),
    .pnl_rst_n(sw_rst_n), .busy(sw_busy));

  int checks = 0, errors = 0;

  function automatic longint cyc_of(input longint us);
    return (us * longint'(HZ) + 999999) / 1000000;
  endfunction

  function automatic logic [15:0] pix_fn(input int i);
    logic [31:0] h;
    h = (32'(i) * 32'h9E37_79B1) ^ 32'h5A3C_0F17;
    return h[23:8];
  endfunction

  // link monitor and stimulus; sole writer of the recorded state
  int cyc = 0, pidx = 0, rq_cnt = 0;
  bit pop_pend = 0, prev_stall = 0, prev_busy = 0, sw_prev_busy = 0;
  logic [7:0] prev_byte = 0;
  logic [8:0] lg [LOGN];
  int n_log = 0, rst_low = 0, srst_cyc = 0, fall_cyc = 0, hold_viol = 0, pops = 0;
  int sw_n = 0, sw_rst_low = 0, sw_srst_cyc = 0, sw_fall_cyc = 0;
  logic [7:0] sw_first = 0;
  bit rd_mode = 0;
  logic [7:0] rd_val = 0;

  assign pix_data = pix_fn(pidx);

  always @(negedge clk) begin
    cyc++;
    if (pop_pend) pidx++;
    lnk_ready = ($urandom % 3) != 0;
    pix_valid = ($urandom % 4) != 0;
    rq_cnt = lnk_rd_req ? rq_cnt + 1 : 0;
    lnk_rd_valid = rd_mode && lnk_rd_req && rq_cnt == 3;
    lnk_rd_data = rd_val;
    #2;
    pop_pend = pix_ready;
    if (pix_ready) pops++;
    if (prev_stall && !(lnk_valid && !lnk_dc && lnk_byte == prev_byte)) hold_viol++;
    prev_stall = lnk_valid && !lnk_ready && !lnk_dc;
    prev_byte = lnk_byte;
    if (lnk_valid && lnk_ready) begin
      lg[n_log % LOGN] = {lnk_dc, lnk_byte};
      n_log++;
      if (!lnk_dc && lnk_byte == 8'h01) srst_cyc = cyc;
    end
    if (!pnl_rst_n) rst_low++;
    if (prev_busy && !busy) fall_cyc = cyc;
    prev_busy = busy;
    if (sw_valid && lnk_ready) begin
      if (sw_n == 0) sw_first = sw_byte;
      sw_n++;
      if (!sw_dc && sw_byte == 8'h01) sw_srst_cyc = cyc;
    end
    if (!sw_rst_n) sw_rst_low++;
    if (sw_prev_busy && !sw_busy) sw_fall_cyc = cyc;
    sw_prev_busy = sw_busy;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected stream
  logic [8:0] ex [LOGN];
  int n_ex;

  task automatic build(input int x0, input int y0, input int x1, input int y1,
                       input bit blank, input int pbase);
    int k;
    int npx;
    ex[0] = {1'b0, 8'h2A};
    ex[1] = {1'b1, 8'(x0 >> 8)}; ex[2] = {1'b1, 8'(x0)};
    ex[3] = {1'b1, 8'((x1 - 1) >> 8)}; ex[4] = {1'b1, 8'(x1 - 1)};
    ex[5] = {1'b0, 8'h2B};
    ex[6] = {1'b1, 8'(y0 >> 8)}; ex[7] = {1'b1, 8'(y0)};
    ex[8] = {1'b1, 8'((y1 - 1) >> 8)}; ex[9] = {1'b1, 8'(y1 - 1)};
    ex[10] = {1'b0, 8'h2C};
    k = 11;
    npx = (x1 - x0) * (y1 - y0);
    for (int p = 0; p < npx; p++) begin
      logic [15:0] v;
      v = blank ? 16'h0000 : pix_fn(pbase + p);
      ex[k] = {1'b1, v[15:8]}; ex[k+1] = {1'b1, v[7:0]};
      k += 2;
    end
    n_ex = k;
  endtask

  task automatic cmp_range(input int base, input int from, input int to, input string tag);
    int bad;
    bad = -1;
    for (int k = from; k < to; k++)
      if (bad < 0 && lg[(base + k) % LOGN] !== ex[k]) bad = k;
    if (bad < 0) chk(1'b1, tag, "stream", 0, 0);
    else chk(1'b0, tag, $sformatf("stream byte %0d {dc,byte}", bad),
             longint'(lg[(base + bad) % LOGN]), longint'(ex[bad]));
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || sw_busy);
    #3;
  endtask

  task automatic pulse(input bit i, input bit c, input bit b, input bit f,
                       input int x0, input int y0, input int x1, input int y1);
    @(negedge clk);
    init_req = i; init_cond = c; blank_req = b; flush_req = f;
    win_x0 = 16'(x0); win_y0 = 16'(y0); win_x1 = 16'(x1); win_y1 = 16'(y1);
    @(negedge clk);
    init_req = 0; init_cond = 0; blank_req = 0; flush_req = 0;
    #1;
  endtask

  task automatic do_flush(input int x0, input int y0, input int x1, input int y1);
    int base, pb, p0;
    base = n_log; pb = pidx; p0 = pops;
    build(x0, y0, x1, y1, 1'b0, pb);
    pulse(0, 0, 0, 1, x0, y0, x1, y1);
    chk(busy, "R10", "busy after flush accept", busy, 1);
    wait_idle();
    chk(n_log - base == n_ex, "R3", "byte count", n_log - base, n_ex);
    cmp_range(base, 0, 11, "R2");
    cmp_range(base, 11, n_ex, "R3");
    chk(pops - p0 == (x1 - x0) * (y1 - y0), "R3", "pixels taken", pops - p0, (x1 - x0) * (y1 - y0));
  endtask

  task automatic do_cond(input bit respond, input logic [7:0] v, input bit expect_on, input string tag);
    int base, rl;
    base = n_log; rl = rst_low;
    rd_mode = respond; rd_val = v;
    pulse(1, 1, 0, 0, 0, 0, 1, 1);
    wait_idle();
    rd_mode = 0;
    chk(lg[base % LOGN] == {1'b0, 8'h0A}, tag, "first byte is power-mode read",
        longint'(lg[base % LOGN]), 10);
    if (expect_on) begin
      chk(n_log - base == 1, tag, "bytes when on", n_log - base, 1);
      chk(rst_low == rl, tag, "no reset pulse when on", rst_low - rl, 0);
    end else begin
      chk(n_log - base == 2 && lg[(base + 1) % LOGN] == {1'b0, 8'h01}, tag,
          "soft reset follows", n_log - base, 2);
      chk(rst_low - rl >= cyc_of(20), tag, "reset pulse length", rst_low - rl, cyc_of(20));
      chk(fall_cyc - srst_cyc - 1 >= cyc_of(5000), tag, "settle after off readback",
          fall_cyc - srst_cyc - 1, cyc_of(5000));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base, rl, p0;
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    #3;
    // R1 reset state
    chk(!busy && !lnk_valid && !lnk_rd_req && !pix_ready && pnl_rst_n, "R1",
        "outputs in reset", {busy, lnk_valid, lnk_rd_req, pix_ready, pnl_rst_n}, 1);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk); #3;
    chk(!busy && !lnk_valid && pnl_rst_n && !sw_busy, "R1", "idle after reset",
        {busy, lnk_valid, pnl_rst_n}, 1);

    // R4 R5 R6 unconditional init on both instances
    base = n_log; rl = rst_low;
    @(negedge clk); init_req = 1; sw_init_req = 1;
    @(negedge clk); init_req = 0; sw_init_req = 0; #1;
    chk(busy && sw_busy, "R10", "busy after init accept", busy, 1);
    wait_idle();
    chk(rst_low - rl >= cyc_of(20) && rst_low - rl <= cyc_of(1000), "R4",
        "reset low cycles", rst_low - rl, cyc_of(20));
    chk(n_log - base == 1 && lg[base % LOGN] == {1'b0, 8'h01}, "R4",
        "only soft reset sent", n_log - base, 1);
    chk(fall_cyc - srst_cyc - 1 >= cyc_of(5000), "R5", "settle cycles",
        fall_cyc - srst_cyc - 1, cyc_of(5000));
    chk(fall_cyc - srst_cyc - 1 < cyc_of(120000), "R5", "short settle chosen",
        fall_cyc - srst_cyc - 1, cyc_of(5000));
    chk(sw_rst_low == 0, "R6", "no pulse without reset line", sw_rst_low, 0);
    chk(sw_n == 1 && sw_first == 8'h01, "R6", "soft reset only", sw_first, 1);
    chk(sw_fall_cyc - sw_srst_cyc - 1 >= cyc_of(120000), "R6", "long settle",
        sw_fall_cyc - sw_srst_cyc - 1, cyc_of(120000));

    // R7 R8 conditional init
    do_cond(1, 8'h9F, 1, "R7");
    do_cond(1, 8'h1C, 1, "R7");
    do_cond(1, 8'h08, 0, "R8");
    do_cond(1, 8'h5C, 0, "R8");
    do_cond(0, 8'h00, 0, "R8");

    // R9 blank
    base = n_log; p0 = pops;
    build(0, 0, PW, PH, 1'b1, 0);
    pulse(0, 0, 1, 0, 5, 1, 7, 2);
    wait_idle();
    chk(n_log - base == n_ex, "R9", "blank byte count", n_log - base, n_ex);
    cmp_range(base, 0, n_ex, "R9");
    chk(pops == p0, "R9", "no pixel taken", pops - p0, 0);

    // directed windows
    do_flush(0, 0, 1, 1);
    do_flush(250, 1, 260, 3);
    do_flush(PW - 1, PH - 1, PW, PH);
    do_flush(0, 0, PW, PH);
    // random windows
    for (int n = 0; n < 10; n++) begin
      int x0, y0, w, h;
      x0 = $urandom % PW; y0 = $urandom % PH;
      w = 1 + ($urandom % 16); h = 1 + ($urandom % PH);
      if (x0 + w > PW) w = PW - x0;
      if (y0 + h > PH) h = PH - y0;
      do_flush(x0, y0, x0 + w, y0 + h);
    end

    // R10 requests while busy are dropped
    base = n_log;
    build(3, 0, 9, 2, 1'b0, pidx);
    pulse(0, 0, 0, 1, 3, 0, 9, 2);
    repeat (4) @(negedge clk);
    pulse(1, 0, 1, 1, 0, 0, 2, 2);
    wait_idle();
    chk(n_log - base == n_ex, "R10", "only first op sent", n_log - base, n_ex);
    cmp_range(base, 0, n_ex, "R10");
    repeat (10) @(negedge clk); #3;
    chk(!busy && n_log - base == n_ex, "R10", "nothing queued", busy, 0);

    // R11 priority
    base = n_log; rl = rst_low;
    pulse(1, 0, 1, 1, 0, 0, 2, 2);
    wait_idle();
    chk(n_log - base == 1 && lg[base % LOGN] == {1'b0, 8'h01} && rst_low > rl, "R11",
        "init wins", n_log - base, 1);
    base = n_log;
    build(0, 0, PW, PH, 1'b1, 0);
    pulse(0, 0, 1, 1, 1, 1, 2, 2);
    wait_idle();
    chk(n_log - base == n_ex, "R11", "blank wins over flush", n_log - base, n_ex);

    chk(hold_viol == 0, "R12", "command hold violations", hold_viol, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule